// File: doc/BRIEF.md
# Multicycle Load-Store Processor Core

This block is a small, non-pipelined processor core. Every instruction passes through a fixed series of phases: fetch, decode, execute, an optional memory-access phase for loads and stores, and a final interrupt-check phase. Only after the check phase does the next fetch begin. The architectural state is a bank of sixteen 32-bit general-purpose registers. The core also holds private registers that software cannot name: the program counter, the instruction register, an operand latch set, an effective-address register, and a shadow register that receives the return address when an interrupt is taken.

Instruction fetches and data accesses share one memory port. That port uses a valid/ready request. The core raises `mem_valid` and then holds `mem_addr`, `mem_we` and `mem_wdata` unchanged until it sees `mem_ready` high on a rising edge. The cycle in which both are high is the transfer. For a read, the memory must present `mem_rdata` in that same cycle. A memory can stretch any access with wait states, for example to model a miss, and the extra cycles show up directly in instruction latency.

A level-sensitive interrupt request is looked at only during the check phase. Two free-running counters report the instructions retired and the clock cycles elapsed since reset. Software performance can therefore be measured as instruction count and total time.

Top module: `mc_core`

## Requirements
- R1: Each instruction runs the phases in a fixed order: fetch, decode, execute, then (loads and stores only) memory, then check, then the next fetch.
- R2: An instruction word has opcode in bits 31:26 (1 clear, 2 load, 3 add, 4 store, 5 increment, 6 branch-if-less), first source register in 25:22, second source register in 21:18, third register in 17:14 and a signed word offset in 13:0. All sixteen registers read zero after reset.
- R3: Load reads the word at address Ra+Rb into Rc. Store writes Rc to address Ra+Rb.
- R4: Add writes Ra+Rb to Rc. Clear writes zero to Rc. Increment writes Rc+1 to Rc.
- R5: Branch-if-less compares Ra and Rb as signed values. When Ra is smaller, the next PC is the branch's own address plus the sign-extended offset. Otherwise the next PC is the following word.
- R6: With no wait states, a register instruction takes 4 cycles and a load or store takes 5. Each wait cycle on fetch or data access adds one cycle.
- R7: While `mem_valid` is high and `mem_ready` is low, the core keeps `mem_valid` high and does not change `mem_addr`, `mem_we` or `mem_wdata` on the next cycle.
- R8: An interrupt is taken only if `irq` is high at the check-phase edge. Taking it stores the next PC in `saved_pc` and makes the next fetch come from address 0x10. When `irq` is high in any other phase, the program flow and `saved_pc` are unchanged.
- R9: `retired` rises by one at each check phase and is steady otherwise. `cycles` counts every clock edge since reset was released.
- R10: An undefined opcode changes no register and no memory word, advances the PC by one, and still retires through the check phase.
- R11: During reset, `retired` and `cycles` read zero and the core requests a fetch from address 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts/completes the request this cycle |
| mem_addr | output | 32 | Word address of the request |
| mem_we | output | 1 | Request is a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the ready cycle |
| irq | input | 1 | Level-sensitive interrupt request |
| saved_pc | output | 32 | Return address captured when an interrupt is taken |
| retired | output | 32 | Instructions completed since reset |
| cycles | output | 32 | Clock cycles since reset release |

## Verification
The properties assume that the memory drives `mem_ready` and `mem_rdata` from the current request only. They also assume that `irq` is a settled level at each rising edge. The bench memory model raises ready after a programmable number of wait cycles, counted from the first cycle of each request, and drops its count after every transfer. The bench changes `irq` and all other inputs only on falling edges. It runs the same vector-add program with different element counts and wait-state settings, so that the hold rule of R7 is exercised across both fetch and data stalls.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

  // Fixed instruction format.
  localparam int ILEN   = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 4;
  localparam int OFF_W  = 14;
  localparam int NREG   = 1 << RIDX_W;

  localparam int OPC_LSB = ILEN - OPC_W;
  localparam int RA_LSB  = OPC_LSB - RIDX_W;
  localparam int RB_LSB  = RA_LSB - RIDX_W;
  localparam int RC_LSB  = RB_LSB - RIDX_W;

  localparam logic [OPC_W-1:0] OPC_CLR = 6'h01;
  localparam logic [OPC_W-1:0] OPC_LD  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_ADD = 6'h03;
  localparam logic [OPC_W-1:0] OPC_ST  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_INC = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BLT = 6'h06;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_DECODE,
    PH_EXEC,
    PH_MEM,
    PH_CHECK
  } phase_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_CLR,
    K_INC,
    K_ADD,
    K_LD,
    K_ST,
    K_BLT
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
    logic [OFF_W-1:0]  off;
  } dec_t;

endpackage

// File: rtl/mc_core_decode.sv
module mc_core_decode
  import mc_core_pkg::*;
(
  input  logic [ILEN-1:0] ir,
  output dec_t            dec
);

  logic [OPC_W-1:0] opc;

  assign opc     = ir[ILEN-1:OPC_LSB];
  assign dec.ra  = ir[RA_LSB +: RIDX_W];
  assign dec.rb  = ir[RB_LSB +: RIDX_W];
  assign dec.rc  = ir[RC_LSB +: RIDX_W];
  assign dec.off = ir[OFF_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_CLR: dec.kind = K_CLR;
      OPC_LD:  dec.kind = K_LD;
      OPC_ADD: dec.kind = K_ADD;
      OPC_ST:  dec.kind = K_ST;
      OPC_INC: dec.kind = K_INC;
      OPC_BLT: dec.kind = K_BLT;
      default: dec.kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/mc_core_regfile.sv
module mc_core_regfile
  import mc_core_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] raddr_a,
  input  logic [RIDX_W-1:0] raddr_b,
  input  logic [RIDX_W-1:0] raddr_c,
  output logic [DW-1:0]     rdata_a,
  output logic [DW-1:0]     rdata_b,
  output logic [DW-1:0]     rdata_c,
  input  logic              wen,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [DW-1:0]     wdata
);

  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wen && (waddr == RIDX_W'(g))) begin
        q <= wdata;
      end
    end
    assign bank[g] = q;
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];
  assign rdata_c = bank[raddr_c];

endmodule

// File: rtl/mc_core_alu.sv
module mc_core_alu
  import mc_core_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  kind_e            kind,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [DW-1:0]    opc,
  input  logic [DW-1:0]    pc,
  input  logic [OFF_W-1:0] off,
  output logic [DW-1:0]    wr_val,
  output logic [DW-1:0]    eff_addr,
  output logic             take,
  output logic [DW-1:0]    target
);

  localparam int EXT_W = DW - OFF_W;

  logic [DW-1:0] sum;

  assign sum      = opa + opb;
  assign eff_addr = sum;
  assign take     = $signed(opa) < $signed(opb);
  assign target   = pc + {{EXT_W{off[OFF_W-1]}}, off};

  always_comb begin
    unique case (kind)
      K_INC:   wr_val = opc + {{(DW-1){1'b0}}, 1'b1};
      K_ADD:   wr_val = sum;
      default: wr_val = '0;
    endcase
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_core_pkg::*;
#(
  parameter int unsigned     DW       = 32,
  parameter int unsigned     CNT_W    = 32,
  parameter logic [DW-1:0]   RESET_PC = 'h20,
  parameter logic [DW-1:0]   IRQ_VEC  = 'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [DW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             irq,
  output logic [DW-1:0]    saved_pc,
  output logic [CNT_W-1:0] retired,
  output logic [CNT_W-1:0] cycles
);

  localparam logic [DW-1:0]    PC_STEP  = 1;
  localparam logic [CNT_W-1:0] CNT_STEP = 1;

  phase_e          phase;
  logic [DW-1:0]   pc;
  logic [DW-1:0]   next_pc;
  logic [DW-1:0]   ea;
  logic [DW-1:0]   opa;
  logic [DW-1:0]   opb;
  logic [DW-1:0]   opc;
  logic [DW-1:0]   shadow_pc;
  logic [ILEN-1:0] ir;
  logic [CNT_W-1:0] ret_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  dec_t            dec;

  logic [DW-1:0] rf_a;
  logic [DW-1:0] rf_b;
  logic [DW-1:0] rf_c;
  logic          rf_wen;
  logic [DW-1:0] rf_wdata;

  logic [DW-1:0] alu_val;
  logic [DW-1:0] alu_ea;
  logic          alu_take;
  logic [DW-1:0] alu_tgt;

  logic is_mem_op;
  logic is_reg_wr;
  logic handshake;

  mc_core_decode u_decode (
    .ir  (ir),
    .dec (dec)
  );

  mc_core_regfile #(.DW(DW)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_a (dec.ra),
    .raddr_b (dec.rb),
    .raddr_c (dec.rc),
    .rdata_a (rf_a),
    .rdata_b (rf_b),
    .rdata_c (rf_c),
    .wen     (rf_wen),
    .waddr   (dec.rc),
    .wdata   (rf_wdata)
  );

  mc_core_alu #(.DW(DW)) u_alu (
    .kind     (dec.kind),
    .opa      (opa),
    .opb      (opb),
    .opc      (opc),
    .pc       (pc),
    .off      (dec.off),
    .wr_val   (alu_val),
    .eff_addr (alu_ea),
    .take     (alu_take),
    .target   (alu_tgt)
  );

  assign is_mem_op = (dec.kind == K_LD) || (dec.kind == K_ST);
  assign is_reg_wr = (dec.kind == K_CLR) || (dec.kind == K_INC) || (dec.kind == K_ADD);
  assign handshake = mem_valid && mem_ready;

  // Register write-back: ALU results in execute, load data on the memory handshake.
  assign rf_wen   = ((phase == PH_EXEC) && is_reg_wr) ||
                    ((phase == PH_MEM) && (dec.kind == K_LD) && mem_ready);
  assign rf_wdata = (phase == PH_MEM) ? mem_rdata : alu_val;

  // Shared memory port driven from registered state only, so it holds during stalls.
  assign mem_valid = (phase == PH_FETCH) || (phase == PH_MEM);
  assign mem_addr  = (phase == PH_MEM) ? ea : pc;
  assign mem_we    = (phase == PH_MEM) && (dec.kind == K_ST);
  assign mem_wdata = opc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FETCH;
      pc        <= RESET_PC;
      next_pc   <= RESET_PC;
      ea        <= '0;
      opa       <= '0;
      opb       <= '0;
      opc       <= '0;
      ir        <= '0;
      shadow_pc <= '0;
      ret_cnt   <= '0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          if (handshake) begin
            ir    <= mem_rdata[ILEN-1:0];
            phase <= PH_DECODE;
          end
        end
        PH_DECODE: begin
          opa   <= rf_a;
          opb   <= rf_b;
          opc   <= rf_c;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          next_pc <= ((dec.kind == K_BLT) && alu_take) ? alu_tgt : pc + PC_STEP;
          if (is_mem_op) begin
            ea    <= alu_ea;
            phase <= PH_MEM;
          end else begin
            phase <= PH_CHECK;
          end
        end
        PH_MEM: begin
          if (handshake) begin
            phase <= PH_CHECK;
          end
        end
        PH_CHECK: begin
          ret_cnt <= ret_cnt + CNT_STEP;
          if (irq) begin
            shadow_pc <= next_pc;
            pc        <= IRQ_VEC;
          end else begin
            pc <= next_pc;
          end
          phase <= PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
    end else begin
      cyc_cnt <= cyc_cnt + CNT_STEP;
    end
  end

  assign saved_pc = shadow_pc;
  assign retired  = ret_cnt;
  assign cycles   = cyc_cnt;

endmodule

// File: rtl/mc_core_sva.sv
module mc_core_sva
  import mc_core_pkg::*;
#(
  parameter int unsigned   DW      = 32,
  parameter int unsigned   CNT_W   = 32,
  parameter logic [DW-1:0] IRQ_VEC = 'h10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [DW-1:0]    mem_addr,
  input logic             mem_we,
  input logic [DW-1:0]    mem_wdata,
  input logic             irq,
  input logic [DW-1:0]    saved_pc,
  input logic [CNT_W-1:0] retired,
  input phase_e           phase,
  input logic [DW-1:0]    pc,
  input kind_e            kind
);

  localparam logic [CNT_W-1:0] ONE = 1;

  p_decode_to_exec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DECODE |=> phase == PH_EXEC);

  p_exec_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EXEC |=> (phase == PH_MEM || phase == PH_CHECK));

  p_regop_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && kind != K_LD && kind != K_ST) |=> phase == PH_CHECK);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_retire_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CHECK |=> retired == $past(retired) + ONE);

  p_retire_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_CHECK |=> $stable(retired));

  p_irq_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHECK && irq) |=> (phase == PH_FETCH && pc == IRQ_VEC));

  p_irq_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_CHECK |=> $stable(saved_pc));

endmodule

bind mc_core mc_core_sva #(
  .DW      (DW),
  .CNT_W   (CNT_W),
  .IRQ_VEC (IRQ_VEC)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .irq       (irq),
  .saved_pc  (saved_pc),
  .retired   (retired),
  .phase     (phase),
  .pc        (pc),
  .kind      (dec.kind)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 256;
  localparam int A_BASE     = 'h40;
  localparam int B_BASE     = 'h60;
  localparam int C_BASE     = 'h80;

  typedef struct packed {
    int unsigned n;
    int unsigned lat;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VEC [NV] = '{'{1, 0}, '{4, 0}, '{3, 2}, '{5, 1}};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_valid;
  logic        mem_ready;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        irq;
  logic [31:0] saved_pc;
  logic [31:0] retired;
  logic [31:0] cycles;

  int n_chk  = 0;
  int n_fail = 0;
  int lat    = 0;
  int wcnt   = 0;
  int viol   = 0;
  bit done   = 0;

  logic [31:0] mem [MEMW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .irq       (irq),
    .saved_pc  (saved_pc),
    .retired   (retired),
    .cycles    (cycles)
  );

  // Memory model with a programmable number of wait cycles per request.
  assign mem_ready = mem_valid && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n || !mem_valid || mem_ready) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (rst_n && mem_valid && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // Request-hold monitor for stalled cycles.
  logic        pv;
  logic [31:0] pa;
  logic [31:0] pd;
  logic        pw;
  always @(negedge clk) begin
    if (!rst_n) begin
      pv = 1'b0;
    end else begin
      if (pv && (!mem_valid || mem_addr != pa || mem_we != pw || mem_wdata != pd)) viol++;
      pv = mem_valid && !mem_ready;
      pa = mem_addr;
      pw = mem_we;
      pd = mem_wdata;
    end
  end

  function automatic logic [31:0] enc(int op, int ra, int rb, int rc, int off);
    return {6'(op), 4'(ra), 4'(rb), 4'(rc), 14'(off)};
  endfunction

  function automatic int a_val(int i);
    return 3 * i + 1;
  endfunction

  function automatic int b_val(int i, int l);
    return 100 + 7 * i + l;
  endfunction

  task automatic load_program(int n, int l);
    for (int k = 0; k < MEMW; k++) mem[k] = '0;
    mem[1] = A_BASE;
    mem[2] = B_BASE;
    mem[3] = C_BASE;
    mem[4] = n;
    mem['h20] = enc(5, 0, 0, 9, 0);
    mem['h21] = enc(2, 9, 0, 1, 0);
    mem['h22] = enc(5, 0, 0, 9, 0);
    mem['h23] = enc(2, 9, 0, 4, 0);
    mem['h24] = enc(5, 0, 0, 9, 0);
    mem['h25] = enc(2, 9, 0, 7, 0);
    mem['h26] = enc(5, 0, 0, 9, 0);
    mem['h27] = enc(2, 9, 0, 8, 0);
    mem['h28] = enc(1, 0, 0, 2, 0);
    mem['h29] = enc(2, 1, 2, 3, 0);
    mem['h2A] = enc(2, 4, 2, 5, 0);
    mem['h2B] = enc(3, 3, 5, 6, 0);
    mem['h2C] = enc(4, 7, 2, 6, 0);
    mem['h2D] = enc(5, 0, 0, 2, 0);
    mem['h2E] = enc(6, 2, 8, 0, -5);
    for (int k = 0; k < n; k++) begin
      mem[A_BASE + k] = a_val(k);
      mem[B_BASE + k] = b_val(k, l);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_retired(int target);
    for (int k = 0; k < 4000 && retired != target; k++) @(negedge clk);
  endtask

  task automatic start(int n, int l);
    rst_n = 1'b0;
    irq   = 1'b0;
    @(negedge clk);
    lat = l;
    load_program(n, l);
    viol = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    irq   = 1'b0;
    load_program(1, 0);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 fetch addr", mem_addr, 32'h20);
    chk("R11 fetch valid", {31'b0, mem_valid}, 32'd1);
    chk("R11 retired", retired, 32'd0);
    chk("R11 cycles", cycles, 32'd0);

    // Vector-add program under several sizes and wait-state settings.
    for (int v = 0; v < NV; v++) begin
      int n;
      int l;
      n = VEC[v].n;
      l = VEC[v].lat;
      start(n, l);
      wait_retired(9 + 6 * n);
      chk("R9 retired count", retired, 9 + 6 * n);
      chk("R6 R1 cycle total", cycles, 40 + 13 * l + n * (27 + 9 * l));
      for (int j = 0; j < n; j++)
        chk("R2 R3 R4 sum element", mem[C_BASE + j], a_val(j) + b_val(j, l));
      chk("R5 loop exit", mem[C_BASE + n], 32'd0);
      chk("R7 request held in stall", viol, 32'd0);
    end

    // R8: interrupt seen in check phase.
    start(2, 0);
    wait_retired(1);
    irq = 1'b1;
    wait_retired(2);
    chk("R8 vector fetch", mem_addr, 32'h10);
    chk("R8 saved pc", saved_pc, 32'h22);
    irq = 1'b0;

    // R10: opcode 0 at the vector is a no-op that still retires in 4 cycles.
    repeat (4) @(negedge clk);
    chk("R10 nop retires", retired, 32'd3);
    chk("R10 nop next pc", mem_addr, 32'h11);

    // R8: a pulse outside the check phase has no effect.
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    wait_retired(4);
    chk("R8 pulse ignored pc", mem_addr, 32'h12);
    chk("R8 pulse ignored saved", saved_pc, 32'h22);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule